// File: doc/BRIEF.md
# Dual-Bank Receive Frame Store

This block takes frames arriving as a byte stream and writes each one into one of two on-chip banks. The banks are called ping and pong. Once the last byte of a frame is stored, the bank's done flag is set and the bank stays locked until the host releases it. The host sees both banks through a 32-bit register window. It reads the packed frame words from the bank base, reads each bank's status word, and writes that status word to release the bank and to control the interrupt enable.

Banks are filled in strict alternation. A new frame always goes to the bank after the one most recently filled. If that bank is still waiting for the host, the whole frame is discarded and a drop counter advances. The host therefore always reads frames in arrival order. The interrupt line pulses for one cycle when a frame completes in a bank whose interrupt enable is set.

Top module: `rx_pingpong_buffer`

## Requirements
- R1: After reset, both status words read 0, `irq` is 0, `drop_count` is 0, and the first frame is stored in the ping bank.
- R2: Frame byte i is stored in word i/4 of its bank, in bits [31-8*(i%4) -: 8], so the first byte is most significant. Unused low bytes of the last word read as 0.
- R3: Byte-address map. Ping words start at 0x1000 and pong words at 0x1800. Their status words sit at 0x17FC and 0x1FFC. In a status word, bit 0 is done, bit 3 is interrupt enable, and all other bits read 0. Reads below 0x1000 return 0. Host writes to frame words are ignored.
- R4: A bank's done bit reads 1 from the cycle after the frame's last byte is accepted.
- R5: Each stored frame goes to the bank other than the one most recently filled.
- R6: If the target bank's done bit is 1 when a frame's first byte arrives, the whole frame is discarded. `drop_count` then rises by exactly 1, the bank contents are unchanged, and the target bank stays the same.
- R7: A host write to a status word stores bit 3 as the enable and clears done when bit 0 is 0. Writing 1 to bit 0 never sets done.
- R8: `irq` is high for exactly the one cycle after a frame's last byte when that bank's enable is 1. It stays low when the enable is 0.
- R9: `bus_rdata` holds the addressed word in the cycle after the one in which `bus_rd` is high.
- R10: Bytes past the bank's last frame word (word BANK_WORDS-2) are discarded. The status word is not disturbed, and done is still set at the frame's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming byte valid |
| in_data | input | 8 | Incoming byte |
| in_last | input | 1 | Marks the final byte of a frame |
| bus_addr | input | 13 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| irq | output | 1 | Frame-complete interrupt pulse |
| drop_count | output | 16 | Count of discarded frames |

## Verification
Read data is due exactly one cycle after the read strobe. The driver places each expected word in a queue when it raises the strobe. A monitor pops that entry on the falling edge after the next rising edge, which is the first point at which the registered data is valid. Done, `irq` and `drop_count` all change on the edge that accepts a frame's last byte (for `drop_count`, its first byte). The bench therefore samples `irq` on the falling edge that follows the last byte. It reads status and the counter only after that point, so no check lands on the edge where a value is still changing.

// File: rtl/rxbuf_pkg.sv
// Shared constants for the dual-bank receive store.
// Assumes a 32-bit host word and exactly two banks.
package rxbuf_pkg;
    localparam int WORD_W   = 32;
    localparam int DONE_BIT = 0;
    localparam int IE_BIT   = 3;
    localparam int NUM_BANK = 2;

    // Builds the status word a host sees for one bank.
    function automatic logic [WORD_W-1:0] status_word(input logic done, input logic ie);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DONE_BIT] = done;
        w[IE_BIT]   = ie;
        return w;
    endfunction
endpackage

// File: rtl/rxbuf_ram.sv
// Two-port word store covering both banks: one write port, one synchronous read port.
// Assumes the read and write addresses never need same-cycle forwarding.
module rxbuf_ram #(
    parameter int AW = 10
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [rxbuf_pkg::WORD_W-1:0] wdata,
    input  logic [AW-1:0]                raddr,
    output logic [rxbuf_pkg::WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [rxbuf_pkg::WORD_W-1:0] mem [DEPTH];

    // Store one word and return the addressed word one cycle later.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rxbuf_bank_status.sv
// Done and interrupt-enable state for one bank.
// Assumes frame completion and a host release never target the same bank in one cycle
// (a frame only completes in a bank whose done is clear). Completion wins if they do.
module rxbuf_bank_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic host_wr,
    input  logic host_done,
    input  logic host_ie,
    output logic done,
    output logic ie,
    output logic irq_pulse
);
    // Done flag: set by a completed frame, cleared only by a host write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                     done <= 1'b0;
        else if (set_done)              done <= 1'b1;
        else if (host_wr && !host_done) done <= 1'b0;
    end

    // Interrupt enable: follows the host's last write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ie <= 1'b0;
        else if (host_wr) ie <= host_ie;
    end

    // One-cycle interrupt when a frame completes while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= set_done && ie;
    end
endmodule

// File: rtl/rxbuf_writer.sv
// Packs the incoming byte stream into words and steers each frame into a bank.
// Assumes one byte per cycle at most and that in_last marks every frame end.
// The bank choice is made on a frame's first byte and held for the whole frame.
module rxbuf_writer #(
    parameter int IDX_W     = 9,
    parameter int CAP_WORDS = 511
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    input  logic                         in_last,
    input  logic [1:0]                   done_vec,
    output logic                         wr_en,
    output logic                         wr_bank,
    output logic [IDX_W-1:0]             wr_idx,
    output logic [rxbuf_pkg::WORD_W-1:0] wr_word,
    output logic                         frame_done,
    output logic                         drop_start
);
    logic                         in_frame, dropping, cur_bank, next_bank;
    logic [1:0]                   byte_pos;
    logic [IDX_W-1:0]             word_idx;
    logic [rxbuf_pkg::WORD_W-1:0] acc;

    logic                         start, discard, bank_sel;
    logic [1:0]                   eff_pos;
    logic [IDX_W-1:0]             eff_idx;
    logic [rxbuf_pkg::WORD_W-1:0] eff_acc, merged;

    // Effective per-byte context: a first byte starts from a clean word.
    always_comb begin
        start    = !in_frame;
        bank_sel = start ? next_bank : cur_bank;
        discard  = start ? done_vec[next_bank] : dropping;
        eff_pos  = start ? 2'd0 : byte_pos;
        eff_idx  = start ? '0 : word_idx;
        eff_acc  = start ? '0 : acc;
    end

    // Insert the new byte below the bytes already collected.
    always_comb begin
        case (eff_pos)
            2'd0:    merged = {in_data, 24'b0};
            2'd1:    merged = {eff_acc[31:24], in_data, 16'b0};
            2'd2:    merged = {eff_acc[31:16], in_data, 8'b0};
            default: merged = {eff_acc[31:8], in_data};
        endcase
    end

    // Write strobes for a full word or the padded tail, and frame events.
    always_comb begin
        wr_en      = in_valid && !discard && (eff_pos == 2'd3 || in_last)
                     && (eff_idx < IDX_W'(CAP_WORDS));
        wr_bank    = bank_sel;
        wr_idx     = eff_idx;
        wr_word    = merged;
        frame_done = in_valid && in_last && !discard;
        drop_start = in_valid && start && done_vec[next_bank];
    end

    // Frame tracking: position, accumulator and bank steering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            dropping  <= 1'b0;
            cur_bank  <= 1'b0;
            next_bank <= 1'b0;
            byte_pos  <= 2'd0;
            word_idx  <= '0;
            acc       <= '0;
        end else if (in_valid) begin
            if (in_last) begin
                in_frame <= 1'b0;
                if (!discard) next_bank <= ~bank_sel;
            end else begin
                in_frame <= 1'b1;
                cur_bank <= bank_sel;
                dropping <= discard;
                if (eff_pos == 2'd3) begin
                    byte_pos <= 2'd0;
                    acc      <= '0;
                    word_idx <= (eff_idx != IDX_W'(CAP_WORDS)) ? eff_idx + 1'b1 : eff_idx;
                end else begin
                    byte_pos <= eff_pos + 2'd1;
                    acc      <= merged;
                    word_idx <= eff_idx;
                end
            end
        end
    end
endmodule

// File: rtl/rx_pingpong_buffer.sv
// Top of the dual-bank receive store: byte-stream input, 32-bit host window, interrupt.
// Assumes word-aligned host addresses and at most one host strobe per cycle.
// The upper half of the window holds the banks; the lower half reads as zero.
module rx_pingpong_buffer #(
    parameter  int BANK_WORDS = 512,
    parameter  int CNT_W      = 16,
    localparam int IDX_W      = $clog2(BANK_WORDS),
    localparam int ADDR_W     = IDX_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [CNT_W-1:0]  drop_count
);
    import rxbuf_pkg::*;

    localparam int CAP_WORDS = BANK_WORDS - 1;

    logic [1:0]       done_vec, ie_vec, irq_vec, host_wr_vec, set_vec;
    logic             wr_en, wr_bank, frame_done, drop_start;
    logic [IDX_W-1:0] wr_idx;
    logic [31:0]      wr_word, ram_q, stat_q;
    logic             in_region, addr_bank, is_stat;
    logic [IDX_W-1:0] addr_idx;
    logic [1:0]       rd_kind;

    // Host address decode: region bit, bank bit, word index.
    always_comb begin
        in_region = bus_addr[ADDR_W-1];
        addr_bank = bus_addr[ADDR_W-2];
        addr_idx  = bus_addr[ADDR_W-3:2];
        is_stat   = in_region && (addr_idx == IDX_W'(CAP_WORDS));
    end

    rxbuf_writer #(.IDX_W(IDX_W), .CAP_WORDS(CAP_WORDS)) writer_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .done_vec(done_vec), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .wr_word(wr_word), .frame_done(frame_done),
        .drop_start(drop_start)
    );

    rxbuf_ram #(.AW(IDX_W + 1)) ram_i (
        .clk(clk), .we(wr_en), .waddr({wr_bank, wr_idx}), .wdata(wr_word),
        .raddr({addr_bank, addr_idx}), .rdata(ram_q)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        // Per-bank strobes from the writer and the host.
        always_comb begin
            set_vec[b]     = frame_done && (wr_bank == b[0]);
            host_wr_vec[b] = bus_wr && is_stat && (addr_bank == b[0]);
        end

        rxbuf_bank_status status_i (
            .clk(clk), .rst_n(rst_n), .set_done(set_vec[b]),
            .host_wr(host_wr_vec[b]), .host_done(bus_wdata[DONE_BIT]),
            .host_ie(bus_wdata[IE_BIT]), .done(done_vec[b]), .ie(ie_vec[b]),
            .irq_pulse(irq_vec[b])
        );
    end

    // Capture what kind of word a read targets and snapshot status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_kind <= 2'd0;
            stat_q  <= '0;
        end else if (bus_rd) begin
            rd_kind <= !in_region ? 2'd0 : (is_stat ? 2'd2 : 2'd1);
            stat_q  <= status_word(done_vec[addr_bank], ie_vec[addr_bank]);
        end
    end

    // Read data select for the cycle after the strobe.
    always_comb begin
        case (rd_kind)
            2'd1:    bus_rdata = ram_q;
            2'd2:    bus_rdata = stat_q;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |irq_vec;

    // Count frames discarded for lack of a free bank.
    always_ff @(posedge clk) begin
        if (!rst_n)          drop_count <= '0;
        else if (drop_start) drop_count <= drop_count + 1'b1;
    end
endmodule

// File: rtl/rxbuf_checker.sv
// Temporal checks for the dual-bank receive store, bound to its top.
module rxbuf_checker #(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_last,
    input logic              irq,
    input logic [CNT_W-1:0]  drop_count,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [1:0]        done_vec
);
    // R8
    irq_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(in_valid && in_last));

    // R8
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_vec != 2'b00));

    // R4
    ping_done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_vec[0]) |-> $past(in_valid && in_last));

    // R4
    pong_done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_vec[1]) |-> $past(in_valid && in_last));

    // R6
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
        (drop_count == $past(drop_count) + CNT_W'(1)) && $past(in_valid));

    // R3
    low_region_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[ADDR_W-1]) |=> (bus_rdata == 32'd0));
endmodule

bind rx_pingpong_buffer rxbuf_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last), .irq(irq),
    .drop_count(drop_count), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .done_vec(done_vec)
);

// File: tb/rx_pingpong_buffer_tb_top.sv
// Scoreboard bench: the driver queues expected read words, a monitor pops and compares.
module rx_pingpong_buffer_tb_top;
    localparam int ADDR_W = 13;
    localparam int CNT_W  = 16;

    localparam logic [12:0] PING = 13'h1000, PONG = 13'h1800;
    localparam logic [12:0] PING_ST = 13'h17FC, PONG_ST = 13'h1FFC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]        in_data = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;
    logic [CNT_W-1:0]  drop_count;

    int n_checks = 0, n_fail = 0;
    int exp_q[$];
    string tag_q[$];
    logic rd_seen = 1'b0;
    logic irq_after = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_pingpong_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq), .drop_count(drop_count)
    );

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + (i >> 8) + 1);
    endfunction

    function automatic logic [31:0] fword(input int seed, input int len, input int w);
        logic [31:0] v = '0;
        for (int k = 0; k < 4; k++)
            if (4 * w + k < len) v[31 - 8 * k -: 8] = fbyte(seed, 4 * w + k);
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: note read strobes at the rising edge, compare on the next falling edge.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, bus_rdata, 32'(e));
        end
    end

    task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(int'(exp));
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic send(input int seed, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fbyte(seed, i); in_last = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        irq_after = irq;
    endtask

    task automatic expect_frame(input logic [12:0] base, input int seed, input int len, input string tag);
        for (int w = 0; w < (len + 3) / 4; w++)
            rd(base + 13'(4 * w), fword(seed, len, w), tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 drop_count", 32'(drop_count), 0);
        rd(PING_ST, 0, "R1 ping status");
        rd(PONG_ST, 0, "R1 pong status");
        rd(13'h0000, 0, "R3 low region");
        rd(13'h0FFC, 0, "R3 low region top");

        // R7 enable write
        wr(PING_ST, 32'h8);
        wr(PONG_ST, 32'h8);
        rd(PING_ST, 32'h8, "R7 ping enable");

        // Frame A into ping (R1 first bank)
        send(1, 10);
        check("R8 irq after ping frame", 32'(irq_after), 1);
        rd(PING_ST, 32'h9, "R4 ping done");
        rd(PONG_ST, 32'h8, "R5 pong still empty");
        expect_frame(PING, 1, 10, "R2 ping frame A");

        // Frame B into pong (R5)
        send(2, 8);
        check("R8 irq after pong frame", 32'(irq_after), 1);
        rd(PONG_ST, 32'h9, "R5 pong done");
        expect_frame(PONG, 2, 8, "R9 pong frame B");

        // Frame C dropped (R6)
        send(3, 5);
        check("R6 drop count", 32'(drop_count), 1);
        check("R6 no irq on drop", 32'(irq_after), 0);
        rd(PING, fword(1, 10, 0), "R6 ping unchanged");

        // Release ping, frame D must land there (R5, R6 target kept)
        wr(PING_ST, 32'h8);
        rd(PING_ST, 32'h8, "R7 ping released");
        send(4, 4);
        rd(PING, fword(4, 4, 0), "R5 frame D in ping");
        rd(PONG, fword(2, 8, 0), "R5 pong keeps B");

        // Release pong with enable off; write of 1 must not set done
        wr(PONG_ST, 32'h0);
        wr(PONG_ST, 32'h1);
        rd(PONG_ST, 32'h0, "R7 write one no set");
        send(5, 1);
        check("R8 no irq with enable off", 32'(irq_after), 0);
        rd(PONG_ST, 32'h1, "R4 pong done after single byte");
        rd(PONG, fword(5, 1, 0), "R2 padding single byte");

        // Host write to frame word ignored (R3)
        wr(PONG, 32'hFFFF_FFFF);
        rd(PONG, fword(5, 1, 0), "R3 frame word write ignored");

        // Overlong frame into ping (R10)
        wr(PING_ST, 32'h8);
        send(6, 2056);
        check("R10 irq after long frame", 32'(irq_after), 1);
        rd(PING_ST, 32'h9, "R10 status intact");
        rd(PING + 13'(4 * 510), fword(6, 2056, 510), "R10 last stored word");
        rd(PING + 13'(4 * 509), fword(6, 2056, 509), "R10 penultimate word");

        // Both full again: drop (R6)
        send(7, 6);
        check("R6 second drop", 32'(drop_count), 2);

        repeat (4) @(negedge clk);
        check("R9 scoreboard drained", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule